// File: doc/BRIEF.md
# Byte-Register UART Transmitter

This block sends serial characters on a single idle-high line. It is set up through a byte-wide register window at offsets 0 to 4. The window holds the following:

- a 16-bit rate divisor, split into low and high bytes;
- a line format register, which sets the word length, the stop-bit count and a latch-select bit;
- an output control register, which drives a request-to-send pin and a user pin that gates an interrupt line.

A host sets the latch-select bit to reach the divisor bytes at offsets 0 and 1. It loads the divisor, then clears the latch-select bit. After that, each write to offset 0 hands one character to the transmitter.

An internal prescaler divides the clock by OVERSAMPLE times the divisor to set the bit period. The prescaler runs only while a frame is on the line, so every frame starts with a full start bit. The shifter sends one low start bit, then 5 to 8 data bits least significant first, then one or two high stop bits. A one-entry holding register lets the host queue the next character while the current one shifts out. The queued character follows the last stop bit with no gap.

Top module: `uart_tx_regs`

## Requirements
- R1: After reset, tx_out is 1, thr_empty is 1, rts_out and irq_gate are 0, the line format register reads 0x00 and the divisor holds RESET_DIV (default 12).
- R2: While line format bit 7 (latch select) is 1, offset 0 writes and reads the divisor low byte and offset 1 writes and reads the divisor high byte. While bit 7 is 0, reads of offsets 0 and 1 return 0x00.
- R3: Every bit of a frame lasts OVERSAMPLE x divisor clock cycles (OVERSAMPLE defaults to 16).
- R4: A divisor of 0 gives a bit period of OVERSAMPLE x 65536 clock cycles.
- R5: A frame is one low start bit, then N data bits least significant first, then the stop bits, which are high. N is 5 plus line format bits 1:0 (00 gives 5, 11 gives 8). tx_out is 1 whenever no frame is being sent.
- R6: Line format bit 2 selects the stop bits: 0 gives one stop bit and 1 gives two.
- R7: While latch select is 1, no new frame starts, and a write to offset 0 changes the divisor rather than queueing a character.
- R8: Line format bits 6:3 are stored and read back at offset 3, and they have no effect on the frames.
- R9: The output control register is at offset 4 and reads back as written. Bit 1 drives rts_out and bit 3 drives irq_gate, both from the cycle after the write.
- R10: A write to offset 0 with latch select 0 fills the holding register and drops thr_empty in the next cycle. The character moves to the shifter as soon as the shifter is idle, or at the end of the last stop bit of the frame in progress, so back-to-back frames leave no idle gap.
- R11: Any write to a divisor byte restarts the prescaler, so the bit in progress lasts a full new period counted from that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tx_out | output | 1 | Serial output, idle high |
| rts_out | output | 1 | Request-to-send, from output control bit 1 |
| irq_gate | output | 1 | User interrupt gate, from output control bit 3 |
| thr_empty | output | 1 | Holding register is empty |

## Verification
The assertions check the following on every cycle:

- the line is high whenever the shifter is idle;
- each frame opens with a low level;
- no frame starts while latch select is set;
- the output pins follow writes to the output control register;
- divisor writes land in the divisor and clear the prescaler;
- the prescaler stays below the current period.

Only the bench scenarios can show the rest. This covers the actual data bit order, word lengths and stop-bit counts on the wire, and bit periods for several divisors including zero. It also covers the lengthened bit after a divisor rewrite in mid-frame, the gap-free back-to-back frames, and the fact that the format bits 6:3 leave the frame unchanged.

// File: rtl/uart_tx_regs.sv
module uart_tx_regs #(
  parameter int OVERSAMPLE = 16,
  parameter int RESET_DIV  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tx_out,
  output logic       rts_out,
  output logic       irq_gate,
  output logic       thr_empty
);
  localparam int DIV_W = 16;
  localparam int CNT_W = DIV_W + $clog2(OVERSAMPLE) + 1;

  logic [7:0] dll, dlm, lcr, mcr, thr, shreg;
  logic       thr_full, busy;
  logic [3:0] bit_idx, wl_q, last_idx;
  logic [CNT_W-1:0] cnt, period;
  logic [DIV_W:0]   div_eff;

  wire latch_sel = lcr[7];
  wire wr_thr    = bus_wr && bus_addr == 3'd0 && !latch_sel;
  wire wr_div    = bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1) && latch_sel;
  wire [3:0] wl_new = 4'd5 + {2'b00, lcr[1:0]};

  assign div_eff = ({dlm, dll} == 16'd0) ? (17'd1 << DIV_W) : {1'b0, dlm, dll};
  assign period  = CNT_W'(div_eff) * CNT_W'(OVERSAMPLE);

  wire end_bit  = busy && !wr_div && cnt == period - CNT_W'(1);
  wire last_bit = end_bit && bit_idx == last_idx;
  wire start    = thr_full && !latch_sel && (!busy || last_bit);

  assign thr_empty = !thr_full;
  assign rts_out   = mcr[1];
  assign irq_gate  = mcr[3];
  assign tx_out    = !busy ? 1'b1 :
                     (bit_idx == 4'd0) ? 1'b0 :
                     (bit_idx <= wl_q) ? shreg[0] : 1'b1;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = latch_sel ? dll : 8'h00;
      3'd1:    bus_rdata = latch_sel ? dlm : 8'h00;
      3'd3:    bus_rdata = lcr;
      3'd4:    bus_rdata = mcr;
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll <= RESET_DIV[7:0];
      dlm <= RESET_DIV[15:8];
      lcr <= 8'h00;
      mcr <= 8'h00;
    end else if (bus_wr) begin
      if (wr_div && bus_addr == 3'd0) dll <= bus_wdata;
      if (wr_div && bus_addr == 3'd1) dlm <= bus_wdata;
      if (bus_addr == 3'd3) lcr <= bus_wdata;
      if (bus_addr == 3'd4) mcr <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= 8'h00;
      thr_full <= 1'b0;
    end else if (wr_thr) begin
      thr      <= bus_wdata;
      thr_full <= 1'b1;
    end else if (start) begin
      thr_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      shreg    <= 8'h00;
      bit_idx  <= 4'd0;
      wl_q     <= 4'd5;
      last_idx <= 4'd0;
      cnt      <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      shreg    <= thr;
      bit_idx  <= 4'd0;
      wl_q     <= wl_new;
      last_idx <= wl_new + (lcr[2] ? 4'd2 : 4'd1);
      cnt      <= '0;
    end else if (last_bit) begin
      busy    <= 1'b0;
      bit_idx <= 4'd0;
      cnt     <= '0;
    end else if (!busy || wr_div) begin
      cnt <= '0;
    end else if (end_bit) begin
      cnt     <= '0;
      bit_idx <= bit_idx + 4'd1;
      if (bit_idx != 4'd0 && bit_idx <= wl_q) shreg <= {1'b0, shreg[7:1]};
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/uart_tx_regs_chk.sv
module uart_tx_regs_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       bus_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input logic             tx_out,
  input logic             rts_out,
  input logic             irq_gate,
  input logic             thr_empty,
  input logic             busy,
  input logic [7:0]       lcr,
  input logic [7:0]       dll,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out); // R5
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_out); // R5
  AST_NO_START_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(lcr[7])); // R7
  AST_CTRL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4) |=> (rts_out == $past(bus_wdata[1]) && irq_gate == $past(bus_wdata[3]))); // R9
  AST_DIV_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && lcr[7]) |=> dll == $past(bus_wdata)); // R2
  AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr <= 3'd1 && lcr[7]) |=> cnt == '0); // R11
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < period); // R3
  AST_HOLD_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && !lcr[7]) |=> !thr_empty); // R10
endmodule

bind uart_tx_regs uart_tx_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .tx_out(tx_out), .rts_out(rts_out),
  .irq_gate(irq_gate), .thr_empty(thr_empty), .busy(busy), .lcr(lcr),
  .dll(dll), .cnt(cnt), .period(period)
);

// File: tb/uart_tx_regs_test.sv
module uart_tx_regs_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic tx_out, rts_out, irq_gate, thr_empty;

  int checks = 0, failures = 0, cycles = 0;
  bit mon_en = 1'b0;
  int cur_wl = 8, cur_st = 1, cur_p = 12;

  typedef struct { logic [7:0] d; int wl; int st; int p; } frame_t;
  frame_t exp_q[$];

  always #4 clk = ~clk;

  uart_tx_regs #(.OVERSAMPLE(1), .RESET_DIV(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_out(tx_out),
    .rts_out(rts_out), .irq_gate(irq_gate), .thr_empty(thr_empty));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [7:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic set_fmt(logic [7:0] v);
    wr(3'd3, v);
    cur_wl = 5 + v[1:0];
    cur_st = v[2] ? 2 : 1;
  endtask

  task automatic set_div(logic [15:0] dv);
    wr(3'd3, 8'h80);
    wr(3'd0, dv[7:0]);
    wr(3'd1, dv[15:8]);
    cur_p = dv;
  endtask

  task automatic send(logic [7:0] d);
    frame_t f;
    f.d = d; f.wl = cur_wl; f.st = cur_st; f.p = cur_p;
    exp_q.push_back(f);
    wr(3'd0, d);
    while (!thr_empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!thr_empty) @(negedge clk);
    repeat (cur_p * 13 + 4) @(negedge clk);
  endtask

  always begin
    @(negedge clk);
    if (mon_en && rst_n && tx_out == 1'b0) begin
      frame_t f;
      logic [7:0] got;
      bit stop_ok;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R7 actual=unexpected frame expected=no frame");
        while (!tx_out) @(negedge clk);
      end else begin
        f = exp_q.pop_front();
        got = 8'h00; stop_ok = 1'b1;
        repeat (f.p / 2) @(negedge clk);
        check("R5 start bit", tx_out, 1'b0);
        for (int k = 0; k < f.wl; k++) begin
          repeat (f.p) @(negedge clk);
          got[k] = tx_out;
        end
        for (int s = 0; s < f.st; s++) begin
          repeat (f.p) @(negedge clk);
          if (tx_out !== 1'b1) stop_ok = 1'b0;
        end
        check("R3 R5 frame data", got, f.d & 8'((1 << f.wl) - 1));
        check("R6 stop bits high", stop_ok, 1'b1);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 tx idle", tx_out, 1'b1);
    check("R1 thr_empty", thr_empty, 1'b1);
    check("R1 rts", rts_out, 1'b0);
    check("R1 irq_gate", irq_gate, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_check("R1 format reg", 3'd3, 8'h00);
    wr(3'd3, 8'h80);
    rd_check("R1 reset divisor low", 3'd0, 8'h0C);
    rd_check("R1 reset divisor high", 3'd1, 8'h00);

    // R2 divisor latch access
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h00);
    rd_check("R2 divisor low", 3'd0, 8'h04);
    rd_check("R2 divisor high", 3'd1, 8'h00);
    cur_p = 4;
    set_fmt(8'h03);
    rd_check("R2 offset0 hidden", 3'd0, 8'h00);
    rd_check("R2 offset1 hidden", 3'd1, 8'h00);
    mon_en = 1'b1;

    // R5 8-bit frames, R3 period 4
    send(8'hA5);
    send(8'h3C);
    wait_idle();
    // R5 5-bit word
    set_fmt(8'h00);
    send(8'hF5);
    wait_idle();
    // R6 two stop bits, 7-bit word
    set_fmt(8'h06);
    send(8'hDA);
    wait_idle();
    // R8 parity/break bits stored and ignored
    set_fmt(8'h7B);
    rd_check("R8 format readback", 3'd3, 8'h7B);
    send(8'h96);
    wait_idle();
    // R3 different divisor
    set_div(16'd3);
    set_fmt(8'h03);
    send(8'h81);
    wait_idle();

    // R10 back-to-back
    send(8'h5A);
    exp_q.push_back('{d: 8'hC3, wl: cur_wl, st: cur_st, p: cur_p});
    wr(3'd0, 8'hC3);
    check("R10 holding full while busy", thr_empty, 1'b0);
    while (!thr_empty) @(negedge clk);
    check("R10 next start without gap", tx_out, 1'b0);
    wait_idle();

    // R7 latch select blocks transmit
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h55);
    check("R7 no holding fill", thr_empty, 1'b1);
    repeat (40) @(negedge clk);
    check("R7 line stays idle", tx_out, 1'b1);
    rd_check("R7 write went to divisor", 3'd0, 8'h55);
    wr(3'd0, 8'h03);
    cur_p = 3;
    set_fmt(8'h03);

    // R9 control pins
    wr(3'd4, 8'h02);
    check("R9 rts high", rts_out, 1'b1);
    check("R9 gate low", irq_gate, 1'b0);
    wr(3'd4, 8'h08);
    check("R9 rts low", rts_out, 1'b0);
    check("R9 gate high", irq_gate, 1'b1);
    rd_check("R9 readback", 3'd4, 8'h08);

    // R11 divisor rewrite restarts prescaler
    mon_en = 1'b0;
    set_div(16'd8);
    set_fmt(8'h03);
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h08);
    wr(3'd3, 8'h03);
    repeat (6) @(negedge clk);
    check("R11 start bit extended", tx_out, 1'b0);
    @(negedge clk);
    check("R11 data bit after full period", tx_out, 1'b1);
    repeat (120) @(negedge clk);

    // R4 divisor zero
    set_div(16'd0);
    set_fmt(8'h03);
    wr(3'd0, 8'h01);
    repeat (65536) @(negedge clk);
    check("R4 start bit still low", tx_out, 1'b0);
    @(negedge clk);
    check("R4 first data bit", tx_out, 1'b1);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset returns idle", tx_out, 1'b1);
    check("R10 queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule